// File: doc/BRIEF.md
# Status and Write-Protect Controller for a Serial Memory

This block keeps the eight-bit status byte of a serial non-volatile memory and decides whether each write request may go ahead. A command decoder in front of it turns serial instructions into single-cycle request pulses:
- set or clear the write-enable latch,
- commit a new status byte,
- commit a write to the memory array at a given address.

The controller checks every write request against three things. The first is the write-enable latch. The second is a block-protect field, which guards an upper share of the array. The third is a hardware-protect mode. That mode locks the status byte whenever the lock bit is set and the write-protect pin is held low.

When the controller accepts a write, it pulses a grant output and starts a self-timed busy interval. During that interval the busy flag and the enable latch keep updating. The lock and block-protect bits keep their old values until the interval ends. A new status value takes effect on the same cycle that the busy flag drops, and the enable latch clears on that cycle too. Reset gives the delivery state, in which nothing is protected.

Top module: `wp_status_ctrl`

## Requirements
- R1: After reset, `status_o` reads 8'h00 and `grant_o` is 0.
- R2: A `req_wren` pulse sets the enable latch (`status_o[1]`) and a `req_wrdi` pulse clears it, both effective after the next clock edge. Both are ignored while the busy flag (`status_o[0]`) is 1.
- R3: The status byte is laid out as:
  - bit 7: lock bit;
  - bits 6:4: always read 0;
  - bits 3:2: block-protect field;
  - bit 1: enable latch;
  - bit 0: busy flag.
- R4: A `req_wrsr` pulse is accepted when all three hold: the enable latch is 1, the controller is idle, and hardware-protect mode is off. Acceptance gives a one-cycle `grant_o` and raises the busy flag. The new lock bit comes from `wrsr_data[7]` and the new block-protect field from `wrsr_data[3:2]`; the other data bits have no effect.
- R5: Hardware-protect mode is on when the lock bit is 1 and `wp_n` is 0. In this mode, a status write is rejected even with the enable latch set: there is no grant, no busy flag, and the status is unchanged. The mode is reached either by lowering `wp_n` after the lock bit is set or by setting the lock bit while `wp_n` is low. Raising `wp_n` ends it.
- R6: With the lock bit at 0, a status write with the enable latch set is accepted whatever the level of `wp_n`.
- R7: The block-protect field guards the following addresses, where DEPTH = 2**ADDR_W:

  | Field | Guarded addresses |
  |---|---|
  | 00 | none |
  | 01 | 3/4·DEPTH and above |
  | 10 | DEPTH/2 and above |
  | 11 | the whole array |

  An array write (`req_write`) to a guarded address is rejected. An array write to any other address is accepted when the enable latch is set and the controller is idle.
- R8: A status or array write with the enable latch at 0 is rejected. A rejected request leaves the enable latch unchanged.
- R9: After an accepted write, the busy flag stays 1 for exactly WRITE_TICKS cycles.
- R10: While the busy flag is 1, the lock bit and block-protect field show their old values. A committed status value appears on the cycle that the busy flag returns to 0.
- R11: The enable latch reads 0 on the cycle that the busy flag returns to 0.
- R12: A status or array write request made while the busy flag is 1 is rejected and gives no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wren | input | 1 | Pulse: set the enable latch |
| req_wrdi | input | 1 | Pulse: clear the enable latch |
| req_wrsr | input | 1 | Pulse: commit a status write |
| wrsr_data | input | 8 | Status byte carried with `req_wrsr` |
| req_write | input | 1 | Pulse: commit an array write |
| write_addr | input | ADDR_W | Target address of `req_write` |
| wp_n | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte (see R3) |
| grant_o | output | 1 | One-cycle pulse when a write is accepted |

At most one request pulse is asserted in any cycle.

## Verification
The bench builds the block with ADDR_W=8 and WRITE_TICKS=5. The 256-entry address space lets random addresses land on both sides of every quarter and half boundary. The short busy interval lets hundreds of writes run back to back. Many requests therefore arrive while the controller is busy, and many status commits can be watched as they switch over on the cycle the busy flag falls.

// File: rtl/wp_ctrl_pkg.sv
// Shared definitions for the status/write-protect controller.
// Assumes a status byte with fixed bit positions that the command
// decoder reads directly.
package wp_ctrl_pkg;
    localparam int SR_BUSY = 0;
    localparam int SR_WEN  = 1;
    localparam int SR_BPLO = 2;
    localparam int SR_BPHI = 3;
    localparam int SR_LOCK = 7;

    typedef enum logic [1:0] {
        GUARD_NONE    = 2'b00,
        GUARD_QUARTER = 2'b01,
        GUARD_HALF    = 2'b10,
        GUARD_ALL     = 2'b11
    } guard_e;

    // Assemble the visible status byte; unused bits read zero.
    function automatic logic [7:0] pack_status(logic lock, guard_e bp,
                                               logic wen, logic busy);
        logic [7:0] s;
        s = 8'h00;
        s[SR_LOCK] = lock;
        s[SR_BPHI:SR_BPLO] = bp;
        s[SR_WEN] = wen;
        s[SR_BUSY] = busy;
        return s;
    endfunction
endpackage

// File: rtl/wp_range_decode.sv
// Decides whether an address lies in the guarded upper share of the array.
// Assumes ADDR_W >= 2 so that quarters of the array exist.
module wp_range_decode
    import wp_ctrl_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  guard_e              bp,
    input  logic [ADDR_W-1:0]   addr,
    output logic                guarded
);
    localparam int TOP = ADDR_W - 1;

    logic in_top_half;
    logic in_top_quarter;

    generate
        if (ADDR_W >= 2) begin : g_split
            assign in_top_half    = addr[TOP];
            assign in_top_quarter = addr[TOP] & addr[TOP-1];
        end else begin : g_tiny
            assign in_top_half    = addr[0];
            assign in_top_quarter = 1'b0;
        end
    endgenerate

    // Select the guarded region from the block-protect field.
    always_comb begin
        unique case (bp)
            GUARD_NONE:    guarded = 1'b0;
            GUARD_QUARTER: guarded = in_top_quarter;
            GUARD_HALF:    guarded = in_top_half;
            default:       guarded = 1'b1;
        endcase
    end
endmodule

// File: rtl/wp_cycle_timer.sv
// Self-timed write interval: busy for exactly TICKS cycles after start.
// done is high in the last busy cycle. start is ignored while busy.
module wp_cycle_timer #(
    parameter int TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(TICKS - 1);

    logic [CW-1:0] left;

    // Load on start, count down while busy, drop busy after the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            left <= '0;
        end else if (busy) begin
            if (left == '0) busy <= 1'b0;
            else            left <= left - 1'b1;
        end else if (start) begin
            busy <= 1'b1;
            left <= LOAD;
        end
    end

    assign done = busy && (left == '0);
endmodule

// File: rtl/wp_status_regs.sv
// Holds the enable latch and the lock/block-protect bits.
// A status commit is staged and applied when the write interval ends,
// so the visible lock/protect bits stay frozen while busy.
module wp_status_regs
    import wp_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_wen,
    input  logic       clr_wen,
    input  logic       stage_sr,
    input  logic [7:0] sr_data,
    input  logic       busy,
    input  logic       done,
    output logic       lock,
    output guard_e     bp,
    output logic       wen
);
    logic   stage_vld;
    logic   stage_lock;
    guard_e stage_bp;

    // Enable latch: cleared at the end of a write, else follows requests when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                wen <= 1'b0;
        else if (done)             wen <= 1'b0;
        else if (!busy && set_wen) wen <= 1'b1;
        else if (!busy && clr_wen) wen <= 1'b0;
    end

    // Stage a new status value and apply it when the interval finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_vld  <= 1'b0;
            stage_lock <= 1'b0;
            stage_bp   <= GUARD_NONE;
            lock       <= 1'b0;
            bp         <= GUARD_NONE;
        end else if (stage_sr) begin
            stage_vld  <= 1'b1;
            stage_lock <= sr_data[SR_LOCK];
            stage_bp   <= guard_e'(sr_data[SR_BPHI:SR_BPLO]);
        end else if (done && stage_vld) begin
            stage_vld <= 1'b0;
            lock      <= stage_lock;
            bp        <= stage_bp;
        end
    end
endmodule

// File: rtl/wp_status_ctrl.sv
// Top of the status/write-protect controller. Qualifies status and
// array write requests against the enable latch, hardware-protect mode
// and the guarded address range, then runs the self-timed interval.
// Assumes at most one request pulse per cycle.
module wp_status_ctrl
    import wp_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int WRITE_TICKS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wren,
    input  logic              req_wrdi,
    input  logic              req_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] write_addr,
    input  logic              wp_n,
    output logic [7:0]        status_o,
    output logic              grant_o
);
    logic   lock, wen, busy, done, guarded;
    guard_e bp;
    logic   hw_locked, sr_ok, arr_ok, start;

    wp_range_decode #(.ADDR_W(ADDR_W)) u_range (
        .bp      (bp),
        .addr    (write_addr),
        .guarded (guarded)
    );

    wp_cycle_timer #(.TICKS(WRITE_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    wp_status_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_wen  (req_wren),
        .clr_wen  (req_wrdi),
        .stage_sr (sr_ok),
        .sr_data  (wrsr_data),
        .busy     (busy),
        .done     (done),
        .lock     (lock),
        .bp       (bp),
        .wen      (wen)
    );

    // Qualify incoming write requests.
    always_comb begin
        hw_locked = lock & ~wp_n;
        sr_ok     = req_wrsr  & wen & ~busy & ~hw_locked;
        arr_ok    = req_write & wen & ~busy & ~guarded;
        start     = sr_ok | arr_ok;
    end

    // One-cycle grant, aligned with the rise of the busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) grant_o <= 1'b0;
        else        grant_o <= start;
    end

    assign status_o = pack_status(lock, bp, wen, busy);
endmodule

// File: rtl/wp_status_ctrl_chk.sv
// Property checker for wp_status_ctrl, attached by bind.
module wp_status_ctrl_chk #(
    parameter int ADDR_W      = 13,
    parameter int WRITE_TICKS = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_wren,
    input logic              req_wrdi,
    input logic              req_wrsr,
    input logic [7:0]        wrsr_data,
    input logic              req_write,
    input logic [ADDR_W-1:0] write_addr,
    input logic              wp_n,
    input logic [7:0]        status_o,
    input logic              grant_o
);
    logic       busy_s, wen_s, lock_s;
    logic [2:0] nv_s;
    int         busy_run;

    assign busy_s = status_o[0];
    assign wen_s  = status_o[1];
    assign lock_s = status_o[7];
    assign nv_s   = {status_o[7], status_o[3:2]};

    // Count consecutive busy cycles for the interval-length check.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_run <= 0;
        else if (busy_s) busy_run <= busy_run + 1;
        else             busy_run <= 0;
    end

    // interface assumption: one request per cycle
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_wren, req_wrdi, req_wrsr, req_write}));

    // R3
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);

    // R4
    grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> busy_s);

    // R8
    grant_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> $past(wen_s));

    // R5
    hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wrsr && lock_s && !wp_n) |=> !grant_o);

    // R12
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_s && (req_wrsr || req_write)) |=> !grant_o);

    // R10
    nv_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(nv_s) |-> $fell(busy_s));

    // R11
    wen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_s) |-> !wen_s);

    // R9
    interval_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_s) |-> (busy_run == WRITE_TICKS));
endmodule

bind wp_status_ctrl wp_status_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .WRITE_TICKS(WRITE_TICKS)
) chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_wren   (req_wren),
    .req_wrdi   (req_wrdi),
    .req_wrsr   (req_wrsr),
    .wrsr_data  (wrsr_data),
    .req_write  (req_write),
    .write_addr (write_addr),
    .wp_n       (wp_n),
    .status_o   (status_o),
    .grant_o    (grant_o)
);

// File: tb/wp_status_ctrl_test.sv
// Bench: directed corner cases plus seeded random traffic, compared
// every cycle against a behavioural model written from the requirements.
module wp_status_ctrl_test;
    localparam int AW    = 8;
    localparam int TICKS = 5;
    localparam int DEPTH = 1 << AW;

    localparam int K_IDLE = 0, K_WREN = 1, K_WRDI = 2, K_WRSR = 3, K_WRITE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_wren = 0, req_wrdi = 0, req_wrsr = 0, req_write = 0;
    logic [7:0]    wrsr_data = 8'h00;
    logic [AW-1:0] write_addr = '0;
    logic          wp_n = 1'b1;
    logic [7:0]    status_o;
    logic          grant_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // model state
    bit       m_lock, m_wen, m_busy, m_grant;
    bit [1:0] m_bp;
    bit       p_vld, p_lock;
    bit [1:0] p_bp;
    int       m_left;

    always #2.5 clk = ~clk;

    wp_status_ctrl #(.ADDR_W(AW), .WRITE_TICKS(TICKS)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_wren(req_wren), .req_wrdi(req_wrdi),
        .req_wrsr(req_wrsr), .wrsr_data(wrsr_data),
        .req_write(req_write), .write_addr(write_addr),
        .wp_n(wp_n), .status_o(status_o), .grant_o(grant_o)
    );

    // R7: guarded range by field value
    function automatic bit guarded(bit [1:0] bp, int addr);
        case (bp)
            2'd0:    return 0;
            2'd1:    return addr >= (DEPTH * 3) / 4;
            2'd2:    return addr >= DEPTH / 2;
            default: return 1;
        endcase
    endfunction

    // R3: expected status byte
    function automatic logic [7:0] exp_status();
        return {m_lock, 3'b000, m_bp, m_wen, m_busy};
    endfunction

    // Model of one clock edge.
    task automatic model_edge(int kind, logic [7:0] d, int addr, bit wp);
        m_grant = 0;
        if (m_busy) begin
            if (m_left == 0) begin
                m_busy = 0;
                m_wen = 0;
                if (p_vld) begin
                    m_lock = p_lock;
                    m_bp = p_bp;
                    p_vld = 0;
                end
            end else m_left--;
        end else begin
            case (kind)
                K_WREN: m_wen = 1;
                K_WRDI: m_wen = 0;
                K_WRSR: if (m_wen && !(m_lock && !wp)) begin
                    m_grant = 1; m_busy = 1; m_left = TICKS - 1;
                    p_vld = 1; p_lock = d[7]; p_bp = d[3:2];
                end
                K_WRITE: if (m_wen && !guarded(m_bp, addr)) begin
                    m_grant = 1; m_busy = 1; m_left = TICKS - 1;
                end
                default: ;
            endcase
        end
    endtask

    task automatic check(string tag);
        checks++;
        if (status_o !== exp_status() || grant_o !== m_grant) begin
            errors++;
            $display("FAIL %s: status=%h grant=%b expected status=%h grant=%b",
                     tag, status_o, grant_o, exp_status(), m_grant);
        end
    endtask

    // Drive one request for one cycle, then compare at the next falling edge.
    task automatic step(int kind, logic [7:0] d, int addr, string tag);
        req_wren  = (kind == K_WREN);
        req_wrdi  = (kind == K_WRDI);
        req_wrsr  = (kind == K_WRSR);
        req_write = (kind == K_WRITE);
        wrsr_data = d;
        write_addr = AW'(addr);
        @(posedge clk);
        model_edge(kind, d, addr, wp_n);
        @(negedge clk);
        req_wren = 0; req_wrdi = 0; req_wrsr = 0; req_write = 0;
        check(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(K_IDLE, 8'h00, 0, tag);
    endtask

    function automatic string pick_tag(int kind, int addr);
        if (m_busy)                             return (kind >= K_WRSR) ? "R12" : "R10";
        if (kind == K_WREN || kind == K_WRDI)   return "R2";
        if (kind >= K_WRSR && !m_wen)           return "R8";
        if (kind == K_WRSR && m_lock && !wp_n)  return "R5";
        if (kind == K_WRSR)                     return "R4";
        if (kind == K_WRITE)                    return "R7";
        return "R9";
    endfunction

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: delivery state
        check("R1");
        // R8: status write without enable latch
        step(K_WRSR, 8'h8C, 0, "R8");
        step(K_WRITE, 8'h00, 5, "R8");
        // R2: set then clear then set
        step(K_WREN, 8'h00, 0, "R2");
        step(K_WRDI, 8'h00, 0, "R2");
        step(K_WREN, 8'h00, 0, "R2");
        // R4, R3: lock=1, spare bits set in data, field=11
        step(K_WRSR, 8'hFC, 0, "R4");
        // R2 and R12 while busy, R10 bits frozen
        step(K_WREN, 8'h00, 0, "R2");
        step(K_WRITE, 8'h00, 1, "R12");
        idle(TICKS - 3, "R10");
        step(K_IDLE, 8'h00, 0, "R11");
        check("R3");
        // R5: lower pin after lock set; rejected even with latch set
        wp_n = 0;
        step(K_WREN, 8'h00, 0, "R2");
        step(K_WRSR, 8'h00, 0, "R5");
        step(K_IDLE, 8'h00, 0, "R5");
        // R5: raise pin ends the mode
        wp_n = 1;
        step(K_WRSR, 8'h00, 0, "R5");
        idle(TICKS, "R9");
        // R6: lock clear, pin low, status write accepted
        wp_n = 0;
        step(K_WREN, 8'h00, 0, "R2");
        step(K_WRSR, 8'h04, 0, "R6");
        idle(TICKS, "R10");
        // R7: quarter boundary
        step(K_WREN, 8'h00, 0, "R2");
        step(K_WRITE, 8'h00, (DEPTH * 3) / 4, "R7");
        step(K_WRITE, 8'h00, (DEPTH * 3) / 4 - 1, "R7");
        idle(TICKS, "R9");
        // R5: lock set while pin already low
        wp_n = 1;
        step(K_WREN, 8'h00, 0, "R2");
        wp_n = 0;
        step(K_WRSR, 8'h88, 0, "R6");
        idle(TICKS, "R10");
        step(K_WREN, 8'h00, 0, "R2");
        step(K_WRSR, 8'h00, 0, "R5");
        step(K_WRITE, 8'h00, DEPTH / 2, "R7");
        step(K_WRITE, 8'h00, DEPTH / 2 - 1, "R7");
        idle(TICKS, "R9");
        wp_n = 1;
        // random traffic
        for (int i = 0; i < 1500; i++) begin
            int k, a;
            logic [7:0] d;
            k = int'($urandom_range(0, 4));
            a = int'($urandom_range(0, DEPTH - 1));
            d = 8'($urandom());
            if ($urandom_range(0, 9) == 0) wp_n = ~wp_n;
            step(k, d, a, pick_tag(k, a));
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule